// File: doc/BRIEF.md
# Label and SDI Match Table Engine

This block sorts received avionics data words by looking them up in a table that the host writes. Four receive channels each hand over 32-bit words. The block takes the words from a waiting slot for each channel in round-robin order and runs one search at a time. A search steps through a 128 × 16-bit match table, one entry per clock, starting at entry 0. It stops at the first entry that accepts the word.

Each entry holds four criteria and two storage options. The criteria are a label (zero acts as a wildcard), a two-bit SDI value with a force-match bit, and a channel number. The storage options are a request to also copy the word into that channel's receive FIFO, and a selector for one of three general-purpose interrupts. The all-call mode is enabled per channel. When it is on, a received SDI of 00 matches any entry SDI.

On a hit, the block presents the index of the matching entry as the store address for a 128-word receive RAM. It holds that address, the word, the channel, the FIFO flag and the interrupt selector until downstream logic accepts them. On a miss it drops the word and raises a one-cycle no-match pulse. Host writes pass through a one-entry pending register and reach the table only while no search is running.

Top module: `label_match_engine`

## Requirements
- R1: An entry's label field (bits 7:0) must equal the word's label (word bits 7:0). An entry label of 8'h00 matches any label.
- R2: An entry's SDI field (bits 9:8) must equal the word's SDI (word bits 9:8), unless entry bit 10 is 1, which makes any SDI match.
- R3: When `all_call_en[c]` is 1, a word on channel c whose SDI is 2'b00 passes the SDI test for every entry. Other SDI values are still compared.
- R4: An entry's channel field (bits 13:12) must equal the number of the channel that delivered the word.
- R5: Entries are tried from index 0 upward, one per clock. The lowest matching index is reported as `res_addr`. The result appears 2+k cycles after the word is taken when entry k is the first match.
- R6: On a hit, `res_to_fifo` equals entry bit 11 and `res_irq_sel` equals entry bits 15:14 (00 means no interrupt).
- R7: If no entry matches, `nomatch` pulses for one cycle with `nomatch_chan` set to the channel and no result is issued. The pulse comes 129 cycles after the word is taken.
- R8: A word on channel c is taken only while `ch_ready[c]` is 1. That flag then stays low until the word's search starts. Waiting channels are served round-robin, starting after the channel served last, with channel 0 first after reset.
- R9: A result stays on `res_valid` with all result fields stable until `res_ready` is 1. No other search starts meanwhile.
- R10: `busy` is 1 from the start of a search until its result is accepted. It is 0 in the cycle of a no-match pulse.
- R11: A host write accepted during a search does not change that search. `host_wr_rdy` stays low until the write lands, and later searches see the new entry.
- R12: After reset, `busy`, `res_valid` and `nomatch` are 0, and `ch_ready` and `host_wr_rdy` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host table write strobe, taken when `host_wr_rdy` is 1 |
| host_addr | input | 7 | Table entry index to write |
| host_wdata | input | 16 | Entry contents |
| host_wr_rdy | output | 1 | Pending write register is free |
| all_call_en | input | 4 | Per-channel all-call enable |
| word_valid | input | 4 | Per-channel word strobe |
| word_data | input | 128 | Received words, channel c at bits 32c+31:32c |
| ch_ready | output | 4 | Per-channel waiting slot is free |
| busy | output | 1 | A search or unaccepted result is in progress |
| res_valid | output | 1 | Match result present |
| res_ready | input | 1 | Downstream accepts the result |
| res_addr | output | 7 | Store address (index of the first matching entry) |
| res_chan | output | 2 | Channel of the matched word |
| res_word | output | 32 | The matched word |
| res_to_fifo | output | 1 | Copy word into the channel FIFO too |
| res_irq_sel | output | 2 | Interrupt selector, 0 means none |
| nomatch | output | 1 | One-cycle pulse: word discarded |
| nomatch_chan | output | 2 | Channel of the discarded word |

## Verification
The properties assume that `res_ready` is a level the consumer may hold low for any length of time. They also assume that strobes on `word_valid` and `host_we` are dropped when the matching ready flag is low. The bench only raises a strobe after seeing the ready flag high at a falling edge, and it keeps each strobe for exactly one clock. Table contents are never left unknown. Every entry is first filled with a neutral value whose label never appears in the stimulus, so the wildcard and channel-0 defaults cannot produce stray hits.

// File: rtl/lm_pkg.sv
// Shared types for the label match engine.
// Assumes a 16-bit table entry; the field order is fixed because the
// host software composes entries by bit position.
package lm_pkg;

    // Table entry, most significant field first (bit 15 down to bit 0)
    typedef struct packed {
        logic [1:0] irq;      // 15:14 interrupt selector, 0 = none
        logic [1:0] chan;     // 13:12 receiving channel
        logic       to_fifo;  // 11    extra copy into channel FIFO
        logic       sdi_any;  // 10    SDI comparison forced true
        logic [1:0] sdi;      // 9:8   SDI value
        logic [7:0] label;    // 7:0   label, 0 = wildcard
    } lm_entry_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_HOLD = 2'd2
    } lm_state_t;

endpackage

// File: rtl/lm_table.sv
// Match table storage with a one-entry pending write register.
// Host writes are parked and only reach the array when commit_ok is high,
// so a running scan always reads a frozen table. Read port is asynchronous.
module lm_table #(
    parameter int DEPTH = 128,
    parameter int DW    = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [DW-1:0]            wr_data,
    output logic                     wr_rdy,
    input  logic                     commit_ok,
    output logic                     pend_busy,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [DW-1:0]            rd_data
);
    localparam int AW = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] pend_addr;
    logic [DW-1:0] pend_data;

    assign wr_rdy  = !pend_busy;
    assign rd_data = mem[rd_addr];

    // Park one host write, release it when the scanner allows
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_busy <= 1'b0;
            pend_addr <= '0;
            pend_data <= '0;
        end else if (wr_en && !pend_busy) begin
            pend_busy <= 1'b1;
            pend_addr <= wr_addr;
            pend_data <= wr_data;
        end else if (pend_busy && commit_ok) begin
            pend_busy <= 1'b0;
        end
    end

    // Array update from the parked write
    always_ff @(posedge clk) begin
        if (pend_busy && commit_ok) begin
            mem[pend_addr] <= pend_data;
        end
    end
endmodule

// File: rtl/lm_rr_arb.sv
// Round-robin selector over N request lines.
// Picks the first requester after the last granted one; the pointer moves
// only when the grant is taken. Starts as if channel N-1 was served last.
module lm_rr_arb #(
    parameter int N = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req,
    input  logic                 take,
    output logic [$clog2(N)-1:0] gnt,
    output logic                 any
);
    localparam int IW = $clog2(N);

    logic [IW-1:0] last;
    logic [IW-1:0] cand;

    // Search backwards so the nearest requester after `last` wins
    always_comb begin
        any  = 1'b0;
        gnt  = last;
        cand = '0;
        for (int i = N; i >= 1; i--) begin
            cand = IW'((int'(last) + i) % N);
            if (req[cand]) begin
                any = 1'b1;
                gnt = cand;
            end
        end
    end

    // Remember the channel served last
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last <= IW'(N - 1);
        end else if (take) begin
            last <= gnt;
        end
    end
endmodule

// File: rtl/lm_entry_cmp.sv
// Compares one table entry against the word under search.
// Purely combinational; assumes word label in bits 7:0 and SDI in 9:8.
module lm_entry_cmp
    import lm_pkg::*;
(
    input  lm_entry_t  ent,
    input  logic [7:0] w_label,
    input  logic [1:0] w_sdi,
    input  logic [1:0] w_chan,
    input  logic       all_call,
    output logic       hit
);
    logic label_ok;
    logic sdi_ok;
    logic chan_ok;

    // Three criteria, all must hold
    always_comb begin
        label_ok = (ent.label == 8'h00) || (ent.label == w_label);
        sdi_ok   = ent.sdi_any || (ent.sdi == w_sdi) || (all_call && (w_sdi == 2'b00));
        chan_ok  = (ent.chan == w_chan);
        hit      = label_ok && sdi_ok && chan_ok;
    end
endmodule

// File: rtl/label_match_engine.sv
// Label/SDI match table engine.
// Takes words from per-channel slots round-robin, scans the match table
// from index 0 one entry per clock and reports the first hit with a
// valid/ready result, or a one-cycle no-match pulse. Assumes at most
// four channels, since an entry carries a two-bit channel field.
module label_match_engine
    import lm_pkg::*;
#(
    parameter int N_CH   = 4,
    parameter int DEPTH  = 128,
    parameter int WORD_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      host_we,
    input  logic [$clog2(DEPTH)-1:0]  host_addr,
    input  logic [15:0]               host_wdata,
    output logic                      host_wr_rdy,
    input  logic [N_CH-1:0]           all_call_en,
    input  logic [N_CH-1:0]           word_valid,
    input  logic [N_CH*WORD_W-1:0]    word_data,
    output logic [N_CH-1:0]           ch_ready,
    output logic                      busy,
    output logic                      res_valid,
    input  logic                      res_ready,
    output logic [$clog2(DEPTH)-1:0]  res_addr,
    output logic [$clog2(N_CH)-1:0]   res_chan,
    output logic [WORD_W-1:0]         res_word,
    output logic                      res_to_fifo,
    output logic [1:0]                res_irq_sel,
    output logic                      nomatch,
    output logic [$clog2(N_CH)-1:0]   nomatch_chan
);
    localparam int                IW       = $clog2(DEPTH);
    localparam int                CH_W     = $clog2(N_CH);
    localparam logic [IW-1:0]     LAST_IDX = IW'(DEPTH - 1);

    lm_state_t          state;
    logic [IW-1:0]      idx;
    logic [WORD_W-1:0]  cur_w;
    logic [CH_W-1:0]    cur_ch;
    logic [N_CH-1:0]    slot_v;
    logic [WORD_W-1:0]  slot_w [N_CH];
    logic [CH_W-1:0]    gnt;
    logic               any_req;
    logic               pend_busy;
    logic               start;
    logic [15:0]        rd_data;
    lm_entry_t          ent;
    logic               hit;

    assign start     = (state == ST_IDLE) && !pend_busy && any_req;
    assign busy      = (state != ST_IDLE);
    assign res_valid = (state == ST_HOLD);
    assign ch_ready  = ~slot_v;
    assign ent       = lm_entry_t'(rd_data);

    // One waiting slot per channel
    for (genvar c = 0; c < N_CH; c++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_v[c] <= 1'b0;
                slot_w[c] <= '0;
            end else if (word_valid[c] && !slot_v[c]) begin
                slot_v[c] <= 1'b1;
                slot_w[c] <= word_data[c*WORD_W +: WORD_W];
            end else if (start && (gnt == CH_W'(c))) begin
                slot_v[c] <= 1'b0;
            end
        end
    end

    lm_rr_arb #(.N(N_CH)) i_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (slot_v),
        .take  (start),
        .gnt   (gnt),
        .any   (any_req)
    );

    lm_table #(.DEPTH(DEPTH), .DW(16)) i_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (host_we),
        .wr_addr   (host_addr),
        .wr_data   (host_wdata),
        .wr_rdy    (host_wr_rdy),
        .commit_ok (state == ST_IDLE),
        .pend_busy (pend_busy),
        .rd_addr   (idx),
        .rd_data   (rd_data)
    );

    lm_entry_cmp i_cmp (
        .ent      (ent),
        .w_label  (cur_w[7:0]),
        .w_sdi    (cur_w[9:8]),
        .w_chan   (2'(cur_ch)),
        .all_call (all_call_en[cur_ch]),
        .hit      (hit)
    );

    // Search sequencer: start, scan one entry per clock, hold the result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            idx          <= '0;
            cur_w        <= '0;
            cur_ch       <= '0;
            res_addr     <= '0;
            res_chan     <= '0;
            res_word     <= '0;
            res_to_fifo  <= 1'b0;
            res_irq_sel  <= 2'b00;
            nomatch      <= 1'b0;
            nomatch_chan <= '0;
        end else begin
            nomatch <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        cur_w  <= slot_w[gnt];
                        cur_ch <= gnt;
                        idx    <= '0;
                        state  <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (hit) begin
                        res_addr    <= idx;
                        res_chan    <= cur_ch;
                        res_word    <= cur_w;
                        res_to_fifo <= ent.to_fifo;
                        res_irq_sel <= ent.irq;
                        state       <= ST_HOLD;
                    end else if (idx == LAST_IDX) begin
                        nomatch      <= 1'b1;
                        nomatch_chan <= cur_ch;
                        state        <= ST_IDLE;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (res_ready) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lm_engine_chk.sv
// Port-level properties of the label match engine, bound to every instance.
// Assumes strobes are only meaningful while the matching ready is high.
module lm_engine_chk #(
    parameter int N_CH   = 4,
    parameter int DEPTH  = 128,
    parameter int WORD_W = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      host_we,
    input logic                      host_wr_rdy,
    input logic [N_CH-1:0]           word_valid,
    input logic [N_CH-1:0]           ch_ready,
    input logic                      busy,
    input logic                      res_valid,
    input logic                      res_ready,
    input logic [$clog2(DEPTH)-1:0]  res_addr,
    input logic [$clog2(N_CH)-1:0]   res_chan,
    input logic [WORD_W-1:0]         res_word,
    input logic                      res_to_fifo,
    input logic [1:0]                res_irq_sel,
    input logic                      nomatch
);
    // R9
    res_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_addr)
                                       && $stable(res_chan) && $stable(res_word)));

    // R6
    fields_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> ($stable(res_to_fifo) && $stable(res_irq_sel)));

    // R10
    busy_with_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> busy);

    // R10
    idle_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nomatch |-> !busy);

    // R7
    miss_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nomatch |=> !nomatch);

    // R7
    miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nomatch |-> !res_valid);

    // R8
    slot_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(word_valid & ch_ready)) |=> ((ch_ready & $past(word_valid & ch_ready)) == '0));

    // R11
    host_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_wr_rdy) |=> !host_wr_rdy);

    // R12
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && !res_valid && !nomatch && host_wr_rdy && (&ch_ready)));
endmodule

bind label_match_engine lm_engine_chk #(
    .N_CH   (N_CH),
    .DEPTH  (DEPTH),
    .WORD_W (WORD_W)
) i_lm_engine_chk (.*);

// File: tb/test_label_match_engine.sv
// Directed bench for the label match engine: one task per scenario.
module test_label_match_engine;
    localparam logic [15:0] NEUTRAL = 16'h00FF;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         host_we = 1'b0;
    logic [6:0]   host_addr = '0;
    logic [15:0]  host_wdata = '0;
    logic         host_wr_rdy;
    logic [3:0]   all_call_en = '0;
    logic [3:0]   word_valid = '0;
    logic [127:0] word_data = '0;
    logic [3:0]   ch_ready;
    logic         busy;
    logic         res_valid;
    logic         res_ready = 1'b1;
    logic [6:0]   res_addr;
    logic [1:0]   res_chan;
    logic [31:0]  res_word;
    logic         res_to_fifo;
    logic [1:0]   res_irq_sel;
    logic         nomatch;
    logic [1:0]   nomatch_chan;

    int n_chk = 0;
    int n_bad = 0;

    logic        g_hit, g_nm, g_busy, g_fifo;
    logic [6:0]  g_addr;
    logic [1:0]  g_chan, g_nmch, g_irq;
    logic [31:0] g_word;
    int          g_cyc;

    always #4 clk = ~clk;

    label_match_engine i_label_match_engine (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ent(input logic [7:0] lbl, input logic [1:0] sdi,
                                        input logic any, input logic fifo,
                                        input logic [1:0] ch, input logic [1:0] irq);
        return {irq, ch, fifo, any, sdi, lbl};
    endfunction

    function automatic logic [31:0] wrd(input logic [7:0] lbl, input logic [1:0] sdi);
        return {22'h2B5A5, sdi, lbl};
    endfunction

    task automatic set_entry(input int i, input logic [15:0] v);
        @(negedge clk);
        while (!host_wr_rdy) @(negedge clk);
        host_we = 1'b1; host_addr = 7'(i); host_wdata = v;
        @(negedge clk);
        host_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic send(input int ch, input logic [31:0] w);
        @(negedge clk);
        while (!ch_ready[ch]) @(negedge clk);
        word_valid[ch] = 1'b1;
        word_data[ch*32 +: 32] = w;
        @(negedge clk);
        word_valid[ch] = 1'b0;
    endtask

    task automatic wait_out();
        g_hit = 1'b0; g_nm = 1'b0; g_cyc = 0;
        for (int k = 1; k <= 400; k++) begin
            @(negedge clk);
            if (res_valid || nomatch) begin
                g_cyc = k; g_hit = res_valid; g_nm = nomatch; g_busy = busy;
                g_addr = res_addr; g_chan = res_chan; g_word = res_word;
                g_fifo = res_to_fifo; g_irq = res_irq_sel; g_nmch = nomatch_chan;
                break;
            end
        end
        if (!g_hit && !g_nm) chk("R7 search outcome seen", 0, 1);
    endtask

    task automatic settle();
        @(negedge clk); @(negedge clk);
    endtask

    task automatic expect_hit(input string req, input int ch, input logic [31:0] w, input int a);
        send(ch, w);
        wait_out();
        chk({req, " hit"}, g_hit, 1);
        chk({req, " addr"}, g_addr, a);
        chk({req, " chan"}, g_chan, ch);
        chk({req, " word"}, g_word, w);
        chk("R10 busy at result", g_busy, 1);
        settle();
    endtask

    task automatic expect_miss(input string req, input int ch, input logic [31:0] w);
        send(ch, w);
        wait_out();
        chk({req, " nomatch"}, g_nm, 1);
        chk({req, " no result"}, g_hit, 0);
        chk({req, " nomatch chan"}, g_nmch, ch);
        chk("R10 idle at nomatch", g_busy, 0);
        settle();
    endtask

    task automatic t_reset();
        chk("R12 busy", busy, 0);
        chk("R12 res_valid", res_valid, 0);
        chk("R12 nomatch", nomatch, 0);
        chk("R12 ch_ready", ch_ready, 4'hF);
        chk("R12 host_wr_rdy", host_wr_rdy, 1);
    endtask

    task automatic t_label();
        set_entry(20, ent(8'h42, 2'b01, 0, 0, 2'd0, 2'd0));
        expect_hit("R1 exact label", 0, wrd(8'h42, 2'b01), 20);
        expect_miss("R1 other label", 0, wrd(8'h43, 2'b01));
        set_entry(20, ent(8'h00, 2'b01, 0, 0, 2'd0, 2'd0));
        expect_hit("R1 wildcard label", 0, wrd(8'h43, 2'b01), 20);
        set_entry(20, NEUTRAL);
    endtask

    task automatic t_sdi();
        set_entry(30, ent(8'h55, 2'b10, 0, 0, 2'd1, 2'd0));
        expect_hit("R2 sdi equal", 1, wrd(8'h55, 2'b10), 30);
        expect_miss("R2 sdi differs", 1, wrd(8'h55, 2'b11));
        set_entry(30, ent(8'h55, 2'b10, 1, 0, 2'd1, 2'd0));
        expect_hit("R2 sdi forced", 1, wrd(8'h55, 2'b11), 30);
        set_entry(30, NEUTRAL);
    endtask

    task automatic t_all_call();
        set_entry(40, ent(8'h66, 2'b01, 0, 0, 2'd2, 2'd0));
        expect_miss("R3 all-call off", 2, wrd(8'h66, 2'b00));
        all_call_en = 4'b0100;
        expect_hit("R3 all-call on", 2, wrd(8'h66, 2'b00), 40);
        expect_miss("R3 all-call other sdi", 2, wrd(8'h66, 2'b11));
        all_call_en = 4'b0000;
        set_entry(40, NEUTRAL);
    endtask

    task automatic t_channel();
        set_entry(45, ent(8'h77, 2'b00, 1, 0, 2'd3, 2'd0));
        expect_miss("R4 wrong channel", 1, wrd(8'h77, 2'b00));
        expect_hit("R4 right channel", 3, wrd(8'h77, 2'b00), 45);
        set_entry(45, NEUTRAL);
    endtask

    task automatic t_priority();
        set_entry(70, ent(8'h21, 2'b00, 1, 1, 2'd0, 2'd2));
        set_entry(90, ent(8'h00, 2'b00, 1, 0, 2'd0, 2'd3));
        expect_hit("R5 first of two", 0, wrd(8'h21, 2'b01), 70);
        chk("R5 latency entry 70", g_cyc, 72);
        chk("R6 fifo flag set", g_fifo, 1);
        chk("R6 irq select 2", g_irq, 2);
        expect_hit("R5 later entry", 0, wrd(8'h22, 2'b01), 90);
        chk("R6 fifo flag clear", g_fifo, 0);
        chk("R6 irq select 3", g_irq, 3);
        set_entry(70, NEUTRAL);
        set_entry(90, NEUTRAL);
        set_entry(127, ent(8'h5A, 2'b00, 1, 0, 2'd1, 2'd0));
        expect_hit("R5 last entry", 1, wrd(8'h5A, 2'b11), 127);
        set_entry(127, NEUTRAL);
        set_entry(0, ent(8'h5B, 2'b00, 1, 0, 2'd1, 2'd1));
        expect_hit("R5 entry zero", 1, wrd(8'h5B, 2'b11), 0);
        chk("R5 latency entry 0", g_cyc, 2);
        chk("R6 irq select 1", g_irq, 1);
        set_entry(0, NEUTRAL);
        send(2, wrd(8'h5C, 2'b00));
        wait_out();
        chk("R7 miss latency", g_cyc, 129);
        chk("R7 miss pulse", g_nm, 1);
        @(negedge clk);
        chk("R7 pulse one cycle", nomatch, 0);
        settle();
    endtask

    task automatic t_hold();
        set_entry(5, ent(8'h31, 2'b00, 1, 0, 2'd0, 2'd1));
        set_entry(6, ent(8'h32, 2'b00, 1, 0, 2'd1, 2'd0));
        res_ready = 1'b0;
        send(0, wrd(8'h31, 2'b00));
        wait_out();
        send(1, wrd(8'h32, 2'b00));
        repeat (10) @(negedge clk);
        chk("R9 still valid", res_valid, 1);
        chk("R9 addr held", res_addr, 5);
        chk("R9 chan held", res_chan, 0);
        chk("R9 irq held", res_irq_sel, 1);
        chk("R9 next word waits", ch_ready[1], 0);
        chk("R10 busy while held", busy, 1);
        res_ready = 1'b1;
        wait_out();
        chk("R9 next result after accept", g_addr, 6);
        chk("R9 next result chan", g_chan, 1);
        settle();
        set_entry(5, NEUTRAL);
        set_entry(6, NEUTRAL);
    endtask

    task automatic t_round_robin();
        for (int c = 0; c < 4; c++) set_entry(10 + c, ent(8'h41, 2'b00, 1, 0, 2'(c), 2'd0));
        res_ready = 1'b0;
        send(0, wrd(8'h41, 2'b00));
        while (!busy) @(negedge clk);
        send(3, wrd(8'h41, 2'b00));
        send(1, wrd(8'h41, 2'b00));
        send(2, wrd(8'h41, 2'b00));
        for (int n = 0; n < 4; n++) begin
            wait_out();
            chk("R8 served channel", g_chan, n);
            chk("R8 matching entry", g_addr, 10 + n);
            res_ready = 1'b1;
            @(negedge clk);
            res_ready = 1'b0;
        end
        res_ready = 1'b1;
        settle();
        for (int c = 0; c < 4; c++) set_entry(10 + c, NEUTRAL);
    endtask

    task automatic t_write_during_scan();
        set_entry(100, ent(8'h51, 2'b00, 1, 0, 2'd2, 2'd0));
        send(2, wrd(8'h51, 2'b00));
        while (!busy) @(negedge clk);
        chk("R10 busy during scan", busy, 1);
        set_entry(50, ent(8'h51, 2'b00, 1, 0, 2'd2, 2'd0));
        chk("R11 write parked", host_wr_rdy, 0);
        wait_out();
        chk("R11 running search unchanged", g_addr, 100);
        settle();
        chk("R11 write landed", host_wr_rdy, 1);
        expect_hit("R11 later search sees write", 2, wrd(8'h51, 2'b00), 50);
        set_entry(50, NEUTRAL);
        set_entry(100, NEUTRAL);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        for (int i = 0; i < 128; i++) set_entry(i, NEUTRAL);
        t_label();
        t_sdi();
        t_all_call();
        t_channel();
        t_priority();
        t_hold();
        t_round_robin();
        t_write_during_scan();
        summary();
    end
endmodule